// File: doc/BRIEF.md
# SIMT Divergence Lane-Mask Stack

This block holds the commit mask of one SIMD thread while its lanes take different sides of a conditional branch. Every lane keeps running every instruction. The block only decides which lanes may write back their results. The mask has one bit per lane, and bit i belongs to lane i. When a divergent branch is entered, the control logic issues a push together with the per-lane branch predicate. At the start of the else side it issues a complement with the same predicate. At the join point it issues a pop. Nested if/else regions use the stack of saved masks, so each join brings back exactly the lanes that were live before the matching branch.

Commands are sampled on the rising clock edge, and the new mask is visible on the output after that edge. An all-zero flag tells the sequencer that no lane would commit on the current path, so the path can be skipped. Two sticky error flags record a push into a full stack and a pop or complement with nothing saved. At most one command acts in a cycle.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, both error flags are low and the stack holds no saved masks.
- R2: A push with a non-full stack saves the current mask and sets the mask to the current mask AND the predicate. Bit i of the predicate applies to lane i.
- R3: A complement with a non-empty stack sets the mask to the top saved mask AND NOT the predicate, and leaves the stack unchanged.
- R4: A pop with a non-empty stack restores the mask from the top saved entry and removes that entry.
- R5: Saved masks come back in last-in first-out order, for nesting up to DEPTH levels.
- R6: A push when DEPTH masks are saved sets the overflow flag and changes neither the mask nor the stack. Both error flags stay high until reset.
- R7: A pop or a complement with an empty stack sets the underflow flag and leaves the mask unchanged.
- R8: When several commands are high in one cycle, only one acts: pop first, then complement, then push. The others are ignored.
- R9: The all-inactive flag is high exactly when the active mask is all zeros, in the same cycle.
- R10: In a cycle with no command the mask holds its value, whatever the predicate is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushCmd | input | 1 | Enter a divergent region with predInput |
| compCmd | input | 1 | Switch to the else side with predInput |
| popCmd | input | 1 | Reconverge and restore the saved mask |
| predInput | input | LANES | Per-lane branch predicate, bit i is lane i |
| activeMask | output | LANES | Per-lane commit enable, bit i is lane i |
| allInactive | output | 1 | High when no lane is enabled |
| overflowErr | output | 1 | Sticky: push attempted with a full stack |
| underflowErr | output | 1 | Sticky: pop or complement with an empty stack |

## Verification
On every cycle, the embedded properties check several things. At most one stack action is chosen per cycle. A push can only clear lanes. A complement keeps the depth and a pop lowers it by one. Both error flags are sticky. The mask holds when the cycle is idle, when a push meets a full stack, and when a pop or complement meets an empty stack. Some behaviour depends on history and only the bench scenarios can show it. These cases are the exact mask values that come back through nested pushes and pops, the else-side mask built from the saved entry, the priority among commands raised together, and the fact that a refused push leaves the saved entries intact for the pops that follow.

// File: rtl/dms_pkg.sv
package dms_pkg;

  // Which command wins arbitration in a cycle
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_POP  = 2'd1,
    SEL_COMP = 2'd2,
    SEL_PUSH = 2'd3
  } cmdSel_t;

  // Strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic doPush;
    logic doComp;
    logic doPop;
  } stackStrb_t;

endpackage

// File: rtl/dms_ctrl.sv
module dms_ctrl
  import dms_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushCmd,
  input  logic       compCmd,
  input  logic       popCmd,
  input  logic       stackEmpty,
  input  logic       stackFull,
  output stackStrb_t strb,
  output logic       overflowErr,
  output logic       underflowErr
);

  cmdSel_t cmdSel;
  logic    setOvf;
  logic    setUnf;

  // Fixed priority: pop, then complement, then push
  always_comb begin
    if (popCmd)       cmdSel = SEL_POP;
    else if (compCmd) cmdSel = SEL_COMP;
    else if (pushCmd) cmdSel = SEL_PUSH;
    else              cmdSel = SEL_NONE;
  end

  always_comb begin
    strb   = '0;
    setOvf = 1'b0;
    setUnf = 1'b0;
    unique case (cmdSel)
      SEL_POP: begin
        if (stackEmpty) setUnf = 1'b1;
        else            strb.doPop = 1'b1;
      end
      SEL_COMP: begin
        if (stackEmpty) setUnf = 1'b1;
        else            strb.doComp = 1'b1;
      end
      SEL_PUSH: begin
        if (stackFull) setOvf = 1'b1;
        else           strb.doPush = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (setOvf) overflowErr  <= 1'b1;
      if (setUnf) underflowErr <= 1'b1;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doPush, strb.doComp, strb.doPop})); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr); // R6
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underflowErr |=> underflowErr); // R7

endmodule

// File: rtl/dms_data.sv
module dms_data
  import dms_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stackStrb_t       strb,
  input  logic [LANES-1:0] predInput,
  output logic [LANES-1:0] curMask,
  output logic             stackEmpty,
  output logic             stackFull
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  spDec;
  logic [IDX_W-1:0] topIdx;
  logic [LANES-1:0] stackMem [DEPTH];
  logic [LANES-1:0] topMask;

  assign spDec      = sp - SP_W'(1);
  assign topIdx     = spDec[IDX_W-1:0];
  assign topMask    = stackMem[topIdx];
  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(DEPTH));

  // Saved entries, each written only on a push at its own level
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                              stackMem[g] <= '1;
      else if (strb.doPush && sp == SP_W'(g)) stackMem[g] <= curMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp      <= '0;
      curMask <= '1;
    end else if (strb.doPush) begin
      sp      <= sp + SP_W'(1);
      curMask <= curMask & predInput;
    end else if (strb.doComp) begin
      curMask <= topMask & ~predInput;
    end else if (strb.doPop) begin
      sp      <= spDec;
      curMask <= topMask;
    end
  end

  AST_PUSH_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush |=> ((curMask & ~$past(curMask)) == '0)); // R2
  AST_COMP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    strb.doComp |=> (sp == $past(sp))); // R3
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop |=> (sp == $past(sp) - SP_W'(1))); // R4
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    sp <= SP_W'(DEPTH)); // R5

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import dms_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushCmd,
  input  logic             compCmd,
  input  logic             popCmd,
  input  logic [LANES-1:0] predInput,
  output logic [LANES-1:0] activeMask,
  output logic             allInactive,
  output logic             overflowErr,
  output logic             underflowErr
);

  stackStrb_t strb;
  logic       stackEmpty;
  logic       stackFull;

  dms_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pushCmd      (pushCmd),
    .compCmd      (compCmd),
    .popCmd       (popCmd),
    .stackEmpty   (stackEmpty),
    .stackFull    (stackFull),
    .strb         (strb),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr)
  );

  dms_data #(.LANES(LANES), .DEPTH(DEPTH)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .predInput  (predInput),
    .curMask    (activeMask),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull)
  );

  assign allInactive = ~|activeMask;

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pushCmd && !compCmd && !popCmd && stackFull) |=> $stable(activeMask)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((popCmd || compCmd) && stackEmpty) |=> $stable(activeMask)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pushCmd && !compCmd && !popCmd) |=> $stable(activeMask)); // R10

endmodule

// File: tb/test_simt_mask_stack.sv
`timescale 1ns/1ps
module test_simt_mask_stack;

  localparam int LANES = 8;
  localparam int DEPTH = 4;
  localparam int NROWS = 22;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pushCmd = 1'b0;
  logic             compCmd = 1'b0;
  logic             popCmd = 1'b0;
  logic [LANES-1:0] predInput = '0;
  logic [LANES-1:0] activeMask;
  logic             allInactive;
  logic             overflowErr;
  logic             underflowErr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_simt_mask_stack (
    .clk          (clk),
    .rstN         (rstN),
    .pushCmd      (pushCmd),
    .compCmd      (compCmd),
    .popCmd       (popCmd),
    .predInput    (predInput),
    .activeMask   (activeMask),
    .allInactive  (allInactive),
    .overflowErr  (overflowErr),
    .underflowErr (underflowErr)
  );

  // Row: {push, comp, pop, pred[7:0], expMask[7:0], expZero, expOvf, expUnf}
  localparam logic [21:0] TBL [NROWS] = '{
    {3'b100, 8'h0F, 8'h0F, 3'b000},
    {3'b100, 8'h05, 8'h05, 3'b000},
    {3'b010, 8'h05, 8'h0A, 3'b000},
    {3'b001, 8'h00, 8'h0F, 3'b000},
    {3'b010, 8'h0F, 8'hF0, 3'b000},
    {3'b100, 8'h0F, 8'h00, 3'b100},
    {3'b000, 8'hAA, 8'h00, 3'b100},
    {3'b001, 8'h00, 8'hF0, 3'b000},
    {3'b110, 8'h3C, 8'hC3, 3'b000},
    {3'b111, 8'h00, 8'hFF, 3'b000},
    {3'b100, 8'hFE, 8'hFE, 3'b000},
    {3'b100, 8'hFC, 8'hFC, 3'b000},
    {3'b100, 8'hF8, 8'hF8, 3'b000},
    {3'b100, 8'hF0, 8'hF0, 3'b000},
    {3'b100, 8'h00, 8'hF0, 3'b010},
    {3'b001, 8'h00, 8'hF8, 3'b010},
    {3'b001, 8'h00, 8'hFC, 3'b010},
    {3'b001, 8'h00, 8'hFE, 3'b010},
    {3'b001, 8'h00, 8'hFF, 3'b010},
    {3'b001, 8'h00, 8'hFF, 3'b011},
    {3'b010, 8'h0F, 8'hFF, 3'b011},
    {3'b100, 8'h80, 8'h80, 3'b011}
  };

  function automatic string reqOf(int idx);
    case (idx)
      0, 1:                   return "R2";  // push narrows, lane bit order
      2, 4:                   return "R3";  // else side from saved top
      3, 7:                   return "R4";  // reconverge
      5:                      return "R9";  // all lanes inactive
      6:                      return "R10"; // idle holds
      8, 9:                   return "R8";  // priority
      10, 11, 12, 13,
      15, 16, 17, 18:         return "R5";  // nesting LIFO
      14, 21:                 return "R6";  // overflow, sticky
      default:                return "R7";  // underflow
    endcase
  endfunction

  task automatic checkOut(string req, logic [10:0] expv);
    logic [10:0] act;
    act = {activeMask, allInactive, overflowErr, underflowErr};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: {mask,zero,ovf,unf} actual=%h expected=%h", req, act, expv);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOut("R1", {8'hFF, 3'b000});
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", {8'hFF, 3'b000});

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      {pushCmd, compCmd, popCmd} = TBL[r][21:19];
      predInput = TBL[r][18:11];
      @(posedge clk);
      #1;
      checkOut(reqOf(r), TBL[r][10:0]);
    end

    @(negedge clk);
    {pushCmd, compCmd, popCmd} = 3'b000;
    // R1: reset in mid-run clears sticky flags and mask
    rstN = 1'b0;
    #1;
    checkOut("R1", {8'hFF, 3'b000});
    @(negedge clk);
    rstN = 1'b1;
    // R1: stack empty after reset, so a pop underflows
    @(negedge clk);
    popCmd = 1'b1;
    @(posedge clk);
    #1;
    checkOut("R1", {8'hFF, 3'b001});
    @(negedge clk);
    popCmd = 1'b0;
    // R7: complement on empty stack with zero predicate still holds mask
    compCmd = 1'b1;
    predInput = 8'h00;
    @(posedge clk);
    #1;
    checkOut("R7", {8'hFF, 3'b001});
    @(negedge clk);
    compCmd = 1'b0;
    // R9: push with zero predicate raises all-inactive
    pushCmd = 1'b1;
    @(posedge clk);
    #1;
    checkOut("R9", {8'h00, 3'b101});
    @(negedge clk);
    pushCmd = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule